// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Reader with Direct Command Port

This block connects a serial flash device to a simple on-chip bus. It offers two regions. A read of the ROM region becomes a complete serial read transaction: the block sends a read opcode and the 24-bit address, clocks in a 32-bit word and returns that word on the bus. The I/O region holds four registers. Through them software can take over the serial port and exchange single raw bytes with the device. This is how erase, program and identification commands are sent.

After reset the block sends one wake-up byte to the device. Until that byte has gone out, the ROM region answers with a bus error. The ROM region also answers with an error while software owns the port (user mode), and for any write. The serial port runs in mode 0 with the most significant bit first. Its clock rate is set by a divider held in the control register.

The bus is a one-beat request/response bus. The master raises `bus_req` with the address, direction and region, and holds them until `bus_ready` pulses for one cycle. On that same cycle `bus_err` and `bus_rdata` carry the result.

Top module: `spi_flash_map`

## Requirements
- R1: After reset, CSN is high and SCK is low. The block then sends the byte 0xAB, MSB first, with CSN low. After that byte, status bit 2 (INIT) reads 1 and status bit 0 (BUSY) reads 0. Before that byte completes, INIT reads 0.
- R2: A ROM-region access made while INIT is 0 gets a response with `bus_err`=1 and causes no read. The status error bit (bit 3) is then set.
- R3: In system mode (control bit 0 = 0), a ROM read at address A sends 0x03 followed by A[23:0], MSB first. It then clocks in 32 bits and returns them with the first received bit as bit 31 and `bus_err`=0.
- R4: A ROM access while control bit 0 (USRC) is 1 gets an error response and produces no SCK edge. It sets status bit 3. Writing 1 to status bit 3 clears that bit.
- R5: A write to the ROM region always gets an error response.
- R6: In user mode with the block idle, a write to register 2 (TX, bits 7:0) sends that byte MSB first. During the transfer BUSY reads 1. Afterwards DONE (status bit 1) is 1, BUSY is 0, and register 3 (RX, bits 7:0) holds the byte received from MISO.
- R7: Writing 1 to status bit 1 clears DONE. Writing 0 to it leaves DONE unchanged.
- R8: `irq` is high exactly when DONE is 1 and control bit 1 (IEN) is 1.
- R9: A write to TX while USRC is 0 is ignored: no SCK edges occur and DONE stays 0.
- R10: In user mode, CSN is low exactly when control bit 2 (UCS) is 1. A TX byte sent with UCS=0 gives eight SCK pulses while CSN stays high.
- R11: Each SCK half period lasts DIV+1 system clocks, where DIV is control bits 11:8 (reset value 1). SCK stays low whenever no transfer is running.
- R12: In system mode, CSN is high whenever no wake-up or ROM read transfer is running. CSN is raised after the last data bit of a ROM read.

Register offsets are selected by `bus_addr[3:2]`: 0 control, 1 status, 2 TX, 3 RX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until `bus_ready` |
| bus_io | input | 1 | 1 selects the I/O register region, 0 the ROM region |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 24 | Byte address (ROM) or register select in bits 3:2 (I/O) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle response strobe |
| bus_err | output | 1 | Error response, valid with `bus_ready` |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| irq | output | 1 | Transfer-done interrupt |
| sck | output | 1 | Serial clock, idles low |
| csn | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
ROM reads are issued at the lowest address, at the top of the address range and at two mixed bit patterns. Each address makes the flash model return a distinct word derived from that address, so a bit-order, byte-order or address-shift error shows up as a wrong word. ROM accesses are also tried in three states: during the wake-up byte, in user mode and as writes. This separates the three error causes from one another and from a good read. User-mode bytes are sent with the device selected and with it deselected, and a TX write is also made outside user mode. Counting SCK edges against the CSN level tells a real transfer from a dummy clocking and from an ignored write. The SCK period is measured at two divider settings.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int SFM_ADDR_W  = 24;
    localparam int SFM_RX_W    = 32;
    localparam int SFM_FRAME_W = 8 + SFM_ADDR_W + SFM_RX_W;
    localparam int SFM_DIV_W   = 4;
    localparam int SFM_CNT_W   = $clog2(SFM_FRAME_W + 1);

    localparam logic [7:0] RD_OPC   = 8'h03;
    localparam logic [7:0] WAKE_OPC = 8'hAB;

    typedef enum logic [2:0] {
        S_INIT_GO,
        S_INIT_WAIT,
        S_IDLE,
        S_ROM_WAIT,
        S_USR_WAIT
    } sfm_state_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TX   = 2'd2,
        REG_RX   = 2'd3
    } sfm_reg_e;

    typedef struct packed {
        logic [SFM_DIV_W-1:0] div;
        logic                 ucs;
        logic                 ien;
        logic                 usrc;
    } sfm_ctrl_t;

    function automatic logic [31:0] pack_ctrl(input sfm_ctrl_t c);
        return {20'b0, c.div, 5'b0, c.ucs, c.ien, c.usrc};
    endfunction

    function automatic sfm_ctrl_t unpack_ctrl(input logic [31:0] w);
        sfm_ctrl_t c;
        c.div  = w[11:8];
        c.ucs  = w[2];
        c.ien  = w[1];
        c.usrc = w[0];
        return c;
    endfunction

endpackage

// File: rtl/sfm_half_tick.sv
module sfm_half_tick #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] reload,
    output logic          tick
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= reload;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/sfm_shift_engine.sv
module sfm_shift_engine #(
    parameter int FRAME_W = 64,
    parameter int RX_W    = 32,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CNT_W-1:0]   nbits,
    input  logic [FRAME_W-1:0] frame,
    input  logic               tick,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               active,
    output logic               done,
    output logic [RX_W-1:0]    rx
);
    logic [FRAME_W-2:0] sh;
    logic [CNT_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            left   <= '0;
            sck    <= 1'b0;
            mosi   <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh     <= frame[FRAME_W-2:0];
                    left   <= nbits;
                    sck    <= 1'b0;
                    mosi   <= frame[FRAME_W-1];
                end
            end else if (tick) begin
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[RX_W-2:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (left == CNT_W'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        left <= left - CNT_W'(1);
                        mosi <= sh[FRAME_W-2];
                        sh   <= {sh[FRAME_W-3:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_flash_map.sv
module spi_flash_map
    import sfm_pkg::*;
#(
    parameter logic [SFM_DIV_W-1:0] DIV_RST = 4'd1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_io,
    input  logic                  bus_we,
    input  logic [SFM_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic                  bus_ready,
    output logic                  bus_err,
    output logic [31:0]           bus_rdata,
    output logic                  irq,
    output logic                  sck,
    output logic                  csn,
    output logic                  mosi,
    input  logic                  miso
);
    sfm_state_e st;
    sfm_ctrl_t  ctl;
    sfm_reg_e   reg_sel;

    logic        done_flag, init_done, err_flag, usr_mode, busy;
    logic [7:0]  rx_byte;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_data, rd_word;

    logic take, take_rom, take_io, rom_bad, rom_go, tx_go, init_go, pending;
    logic                   eng_start, eng_active, eng_done, eng_tick, eng_sck, eng_mosi;
    logic [SFM_CNT_W-1:0]   eng_nbits;
    logic [SFM_FRAME_W-1:0] eng_frame;
    logic [SFM_RX_W-1:0]    eng_rx;

    assign usr_mode = ctl.usrc;
    assign busy     = (st != S_IDLE);
    assign pending  = (st == S_ROM_WAIT);
    assign reg_sel  = sfm_reg_e'(bus_addr[3:2]);

    assign take     = bus_req && !rsp_valid && !pending;
    assign take_rom = take && !bus_io;
    assign take_io  = take && bus_io;
    assign rom_bad  = bus_we || !init_done || ctl.usrc || (st != S_IDLE);
    assign rom_go   = take_rom && !rom_bad;
    assign tx_go    = take_io && bus_we && (reg_sel == REG_TX) && ctl.usrc && (st == S_IDLE);
    assign init_go  = (st == S_INIT_GO);
    assign eng_start = init_go || rom_go || tx_go;

    always_comb begin
        eng_nbits = SFM_CNT_W'(8);
        if (init_go) begin
            eng_frame = {WAKE_OPC, {(SFM_FRAME_W-8){1'b0}}};
        end else if (rom_go) begin
            eng_frame = {RD_OPC, bus_addr, {SFM_RX_W{1'b0}}};
            eng_nbits = SFM_CNT_W'(SFM_FRAME_W);
        end else begin
            eng_frame = {bus_wdata[7:0], {(SFM_FRAME_W-8){1'b0}}};
        end
    end

    always_comb begin
        case (reg_sel)
            REG_CTRL: rd_word = pack_ctrl(ctl);
            REG_STAT: rd_word = {28'b0, err_flag, init_done, done_flag, busy};
            REG_RX:   rd_word = {24'b0, rx_byte};
            default:  rd_word = '0;
        endcase
    end

    sfm_half_tick #(.CW(SFM_DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (eng_active),
        .reload (ctl.div),
        .tick   (eng_tick)
    );

    sfm_shift_engine #(
        .FRAME_W (SFM_FRAME_W),
        .RX_W    (SFM_RX_W),
        .CNT_W   (SFM_CNT_W)
    ) u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .nbits  (eng_nbits),
        .frame  (eng_frame),
        .tick   (eng_tick),
        .miso   (miso),
        .sck    (eng_sck),
        .mosi   (eng_mosi),
        .active (eng_active),
        .done   (eng_done),
        .rx     (eng_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_INIT_GO;
            ctl       <= '{div: DIV_RST, ucs: 1'b0, ien: 1'b0, usrc: 1'b0};
            done_flag <= 1'b0;
            init_done <= 1'b0;
            err_flag  <= 1'b0;
            rx_byte   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            case (st)
                S_INIT_GO:   st <= S_INIT_WAIT;
                S_INIT_WAIT: if (eng_done) begin
                    init_done <= 1'b1;
                    st        <= S_IDLE;
                end
                S_ROM_WAIT:  if (eng_done) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= eng_rx;
                    st        <= S_IDLE;
                end
                S_USR_WAIT:  if (eng_done) begin
                    done_flag <= 1'b1;
                    rx_byte   <= eng_rx[7:0];
                    st        <= S_IDLE;
                end
                default: begin
                    if (rom_go)     st <= S_ROM_WAIT;
                    else if (tx_go) st <= S_USR_WAIT;
                end
            endcase

            if (take_rom && rom_bad) begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                err_flag  <= 1'b1;
            end

            if (take_io) begin
                rsp_valid <= 1'b1;
                if (!bus_we) rsp_data <= rd_word;
                if (bus_we && reg_sel == REG_CTRL) ctl <= unpack_ctrl(bus_wdata);
                if (bus_we && reg_sel == REG_STAT) begin
                    if (bus_wdata[1]) done_flag <= 1'b0;
                    if (bus_wdata[3]) err_flag  <= 1'b0;
                end
            end
        end
    end

    assign bus_ready = rsp_valid;
    assign bus_err   = rsp_err;
    assign bus_rdata = rsp_data;
    assign irq       = done_flag && ctl.ien;
    assign sck       = eng_sck;
    assign mosi      = eng_mosi;
    assign csn       = !((st == S_INIT_WAIT) || (st == S_ROM_WAIT) || (ctl.usrc && ctl.ucs));
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_io,
    input logic       bus_we,
    input logic [1:0] bus_sel,
    input logic       clr_done_bit,
    input logic       bus_ready,
    input logic       bus_err,
    input logic       sck,
    input logic       csn,
    input logic       usr_mode,
    input logic       init_done,
    input logic       eng_active,
    input logic       eng_done,
    input logic       done_flag
);
    // R12
    csn_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!eng_active && !eng_done && !usr_mode) |-> csn);

    // R11
    sck_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_active |-> !sck);

    // R2
    early_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_io && !init_done && !bus_ready) |=> (bus_ready && bus_err));

    // R4
    user_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_io && usr_mode && !bus_ready) |=> (bus_ready && bus_err));

    // R5
    rom_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_io && bus_we && !bus_ready) |=> (bus_ready && bus_err));

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_flag) |-> $past(bus_req && bus_io && bus_we && bus_sel == 2'd1 && clr_done_bit));
endmodule

bind spi_flash_map sfm_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_req      (bus_req),
    .bus_io       (bus_io),
    .bus_we       (bus_we),
    .bus_sel      (bus_addr[3:2]),
    .clr_done_bit (bus_wdata[1]),
    .bus_ready    (bus_ready),
    .bus_err      (bus_err),
    .sck          (sck),
    .csn          (csn),
    .usr_mode     (usr_mode),
    .init_done    (init_done),
    .eng_active   (eng_active),
    .eng_done     (eng_done),
    .done_flag    (done_flag)
);

// File: tb/spi_flash_map_test.sv
`timescale 1ns/1ps
module spi_flash_map_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_io = 1'b0, bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_err, irq, sck, csn, mosi;
    logic [31:0] bus_rdata;
    logic        miso = 1'b1;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    spi_flash_map uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_io(bus_io), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .irq(irq), .sck(sck),
        .csn(csn), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fdata(input logic [23:0] a);
        return {a, 8'h5A} ^ 32'hC3A5_0F1E;
    endfunction

    // ---------------- flash model ----------------
    localparam logic [7:0] REPLY = 8'h96;
    logic [7:0]  exp_byte = 8'hAB;
    logic [31:0] cmd_q[$];
    int          fcnt = 0;
    logic [31:0] fsh  = '0;

    always @(posedge sck) begin
        if (!csn) begin
            if (fcnt < 32) fsh = {fsh[30:0], mosi};
            fcnt++;
        end
    end

    always @(negedge sck) begin
        if (!csn) begin
            logic [31:0] w;
            w = fdata(fsh[23:0]);
            if (fcnt < 8)                    miso = REPLY[7-fcnt];
            else if (fcnt >= 32 && fcnt < 64) miso = w[63-fcnt];
            else                              miso = 1'b0;
        end
    end

    always @(posedge csn) begin
        if (fcnt == 64) begin
            if (cmd_q.size() == 0) chk(1'b0, "R3 unexpected read frame", fsh, 32'h0);
            else begin
                logic [31:0] e;
                e = cmd_q.pop_front();
                chk(fsh == e, "R3 opcode+address on MOSI", fsh, e);
            end
        end else if (fcnt == 8) begin
            // R1 wake byte / R6 user byte on MOSI
            chk(fsh[7:0] == exp_byte, "R1/R6 byte on MOSI", {24'b0, fsh[7:0]}, {24'b0, exp_byte});
        end
        fcnt = 0;
        miso = REPLY[7];
    end

    // ---------------- SCK edge bookkeeping ----------------
    int  rises = 0;
    int  rise_hi = 0;
    real last_rise = 0.0;
    real per = 0.0;
    always @(posedge sck) begin
        rises++;
        if (csn) rise_hi++;
        per = $realtime - last_rise;
        last_rise = $realtime;
    end

    // ---------------- scoreboard ----------------
    logic [32:0] rom_q[$];
    string       tag_q[$];

    always @(negedge clk) begin
        if (!rst && bus_ready && !bus_io) begin
            if (rom_q.size() == 0) chk(1'b0, "ROM response not expected", bus_rdata, 32'h0);
            else begin
                logic [32:0] e;
                string t;
                e = rom_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_err == e[32], {t, " err"}, {31'b0, bus_err}, {31'b0, e[32]});
                if (!e[32]) chk(bus_rdata == e[31:0], {t, " data"}, bus_rdata, e[31:0]);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic bus_op(input bit io, input bit we, input logic [23:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_io = io; bus_we = we; bus_addr = a; bus_wdata = wd;
        do @(negedge clk); while (!bus_ready);
        rd = bus_rdata;
        er = bus_err;
        bus_req = 1'b0;
    endtask

    task automatic rom_op(input bit we, input logic [23:0] a, input bit exp_err, input string tag);
        logic [31:0] rd;
        logic er;
        if (!exp_err) cmd_q.push_back({8'h03, a});
        rom_q.push_back({exp_err, exp_err ? 32'h0 : fdata(a)});
        tag_q.push_back(tag);
        bus_op(1'b0, we, a, 32'h0, rd, er);
    endtask

    task automatic io_wr(input logic [1:0] r, input logic [31:0] d);
        logic [31:0] rd;
        logic er;
        bus_op(1'b1, 1'b1, {20'b0, r, 2'b0}, d, rd, er);
    endtask

    task automatic io_rd(input logic [1:0] r, output logic [31:0] d);
        logic er;
        bus_op(1'b1, 1'b0, {20'b0, r, 2'b0}, 32'h0, d, er);
    endtask

    task automatic wait_stat_bit(input int b);
        logic [31:0] s;
        s = '0;
        while (!s[b]) io_rd(2'd1, s);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v;
        int r0, h0;
        repeat (4) @(negedge clk);
        chk(csn == 1'b1, "R1 CSN high in reset", {31'b0, csn}, 32'h1);
        chk(sck == 1'b0, "R1 SCK low in reset", {31'b0, sck}, 32'h0);
        rst = 1'b0;

        // R2: ROM read during wake-up byte
        rom_op(1'b0, 24'h000100, 1'b1, "R2 ROM during init");
        io_rd(2'd1, v);
        chk(v[3:0] == 4'b1001, "R1/R2 status during init", v, 32'h9);

        wait_stat_bit(2);
        io_rd(2'd1, v);
        chk(v == 32'h0000_000C, "R1 status after init", v, 32'hC);
        io_wr(2'd1, 32'h8);
        io_rd(2'd1, v);
        chk(v == 32'h0000_0004, "R4 error bit cleared", v, 32'h4);

        // R3: system-mode reads
        rom_op(1'b0, 24'h000000, 1'b0, "R3 addr low");
        chk(csn == 1'b1, "R12 CSN high after read", {31'b0, csn}, 32'h1);
        chk(per == 20.0, "R11 SCK period div=1", $rtoi(per), 32'd20);
        rom_op(1'b0, 24'hFFFFFC, 1'b0, "R3 addr top");
        rom_op(1'b0, 24'h123454, 1'b0, "R3 addr mix1");
        rom_op(1'b0, 24'hA5A5A4, 1'b0, "R3 addr mix2");
        chk(csn == 1'b1, "R12 CSN idle", {31'b0, csn}, 32'h1);

        // R5
        rom_op(1'b1, 24'h000040, 1'b1, "R5 ROM write");

        // R11: slower clock
        io_wr(2'd0, 32'h0000_0300);
        io_rd(2'd0, v);
        chk(v == 32'h0000_0300, "R11 control readback", v, 32'h300);
        rom_op(1'b0, 24'h0F0F08, 1'b0, "R3 addr div3");
        chk(per == 40.0, "R11 SCK period div=3", $rtoi(per), 32'd40);
        io_wr(2'd0, 32'h0000_0100);

        // R4: ROM in user mode
        io_wr(2'd0, 32'h0000_0101);
        r0 = rises;
        rom_op(1'b0, 24'h000200, 1'b1, "R4 ROM in user mode");
        repeat (20) @(negedge clk);
        chk(rises == r0, "R4 no SCK on refused ROM", rises, r0);
        io_rd(2'd1, v);
        chk(v[3] == 1'b1, "R4 error bit set", v, 32'hC);
        io_wr(2'd1, 32'h8);

        // R10: byte with device deselected
        h0 = rise_hi;
        io_wr(2'd2, 32'h0000_00FF);
        wait_stat_bit(1);
        chk(rise_hi == h0 + 8, "R10 eight SCK with CSN high", rise_hi, h0 + 8);
        io_rd(2'd1, v);
        chk(v == 32'h0000_0006, "R6 DONE set BUSY clear", v, 32'h6);
        io_wr(2'd1, 32'h0);
        io_rd(2'd1, v);
        chk(v[1] == 1'b1, "R7 write 0 keeps DONE", v, 32'h6);
        io_wr(2'd1, 32'h2);
        io_rd(2'd1, v);
        chk(v == 32'h0000_0004, "R7 write 1 clears DONE", v, 32'h4);

        // R6/R8/R10: selected byte
        io_wr(2'd0, 32'h0000_0105);
        chk(csn == 1'b0, "R10 CSN follows UCS", {31'b0, csn}, 32'h0);
        exp_byte = 8'h3C;
        io_wr(2'd2, 32'h0000_003C);
        io_rd(2'd1, v);
        chk(v[0] == 1'b1, "R6 BUSY during transfer", v, 32'h5);
        wait_stat_bit(1);
        chk(irq == 1'b0, "R8 irq off with IEN=0", {31'b0, irq}, 32'h0);
        io_rd(2'd3, v);
        chk(v == {24'b0, REPLY}, "R6 RX byte", v, {24'b0, REPLY});
        io_wr(2'd0, 32'h0000_0107);
        chk(irq == 1'b1, "R8 irq on", {31'b0, irq}, 32'h1);
        io_wr(2'd1, 32'h2);
        chk(irq == 1'b0, "R8 irq off after clear", {31'b0, irq}, 32'h0);
        io_wr(2'd0, 32'h0000_0103);
        chk(csn == 1'b1, "R10 CSN released", {31'b0, csn}, 32'h1);

        // R9: TX outside user mode
        io_wr(2'd0, 32'h0000_0100);
        r0 = rises;
        io_wr(2'd2, 32'h0000_0055);
        repeat (60) @(negedge clk);
        chk(rises == r0, "R9 no SCK on ignored TX", rises, r0);
        io_rd(2'd1, v);
        chk(v[1] == 1'b0, "R9 DONE stays 0", v, 32'h4);

        rom_op(1'b0, 24'h3C3C30, 1'b0, "R3 read after user mode");
        repeat (5) @(negedge clk);
        chk(rom_q.size() == 0 && cmd_q.size() == 0, "R3 scoreboard drained",
            rom_q.size() + cmd_q.size(), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule